// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block sits between an on-chip requester and an asynchronous DRAM that has a 4-bit data path and extended-data-out reads. It takes single-word read and write requests on a valid/ready port. Each request carries a 22-bit word address. The controller splits that address into a row half and a column half, drives them onto one shared address bus, and sequences the active-low row strobe, column strobe, write enable and output enable. Read data returns as a one-cycle response.

A row stays open after an access. A later request that targets the same row is served with a column cycle only, so the row strobe stays low. The controller closes the row in three cases: a request to another row arrives, an external refresh scheduler asks for the bus, or the row has been low long enough to come near its allowed maximum. Reads are sampled after the column strobe has already risen again, while the output enable is still held low. This lets the next column cycle start without waiting for the data to settle during the strobe.

Every timing minimum is given in nanoseconds together with the clock period. The controller rounds each one up to a whole number of cycles.

Top module: `edo_page_ctrl`

## Requirements
- R1: The row address `reqAddr[21:11]` is on `dramA` when `dramRasN` falls. The column address `reqAddr[10:0]` is on `dramA` when `dramCasN` falls.
- R2: For a read, `dramWeN` stays high and `dramOeN` stays low until the data is sampled. `rspValid` pulses for one cycle with the word last written to that address.
- R3: A write is an early write. `dramWeN` is low and `dramDqOe` is high for at least one cycle before `dramCasN` falls. `dramOeN` is high whenever `dramWeN` is low. `dramDqOe` is never high unless `dramWeN` is low.
- R4: A request to the open row, with no refresh pending, is served without a new `dramRasN` fall. Only one extra `dramCasN` fall occurs. Read data is sampled while `dramCasN` is high.
- R5: After `dramRasN` rises, it stays high for at least ceil(T_RC-T_RAS, T_RP) cycles before it falls again. With the defaults this is 7 cycles.
- R6: `dramRasN` is never low for more than ceil(T_RASMAX_NS/CLK_NS) cycles. With no traffic, an open row is closed on its own before that limit.
- R7: While `refReq` is high, `reqReady` is low. The controller closes any open row, lowers `dramCasN` before `dramRasN` (refresh with an internal row counter), and pulses `refAck` for exactly one cycle. If refresh and a request arrive in the same idle cycle, refresh goes first.
- R8: The row-to-column strobe delay is at least ceil(T_RCD_NS/CLK_NS) cycles. The low time of `dramCasN` in a column cycle is exactly ceil(T_CAS_NS/CLK_NS) cycles, which is 2 with the defaults.
- R9: During and after reset, all strobes are high, `dramDqOe` is low, `rspValid` and `refAck` are low, and `reqReady` is high.
- R10: `dramRasN` stays low for at least ceil(T_RAS_NS/CLK_NS) cycles, which is 12 with the defaults, even when a row miss arrives at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request accepted this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address, row in the upper ROW_W bits |
| reqWdata | input | DQ_W | Write data |
| rspValid | output | 1 | Read data valid pulse |
| rspData | output | DQ_W | Read data |
| refReq | input | 1 | Refresh request from the scheduler (level) |
| refAck | output | 1 | One-cycle pulse: refresh cycle done |
| dramA | output | PIN_W | Multiplexed row/column address |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramDq | output | DQ_W | Write data to the pads |
| dramDqOe | output | 1 | Pad drive enable for dramDq |
| dramDqIn | input | DQ_W | Read data from the pads |

## Verification
The case that matters is a refresh request and a host request that reach the idle controller in the same cycle. The bench raises `refReq` and `reqValid` at the same clock edge. It then checks three things: `reqReady` stays low, a column-before-row refresh strobe pair appears with a single-cycle `refAck`, and only after `refReq` drops is the held read accepted and answered with the stored word. A second overlap is also exercised: an open page running into its RAS-low limit while idle. This is judged by the row closing on its own and by the longest measured RAS-low run staying within the limit.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ROW, ST_COLSET, ST_CASLO, ST_CASHI,
    ST_OPEN, ST_PRE, ST_REFCAS, ST_REFRAS
  } edoState_t;

  // strobes from control to datapath, registered onto the pins by the datapath
  typedef struct packed {
    logic capture;
    logic colSel;
    logic rasOn;
    logic casOn;
    logic weOn;
    logic oeOn;
    logic dqDrive;
    logic sample;
    logic ack;
  } edoStrobe_t;

  function automatic int cdiv(input int ns, input int clkNs);
    return (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_ctrl.sv
module edo_ctrl
  import edo_pkg::*;
#(
  parameter int RCD_CYC    = 3,
  parameter int CAS_CYC    = 2,
  parameter int CPW_CYC    = 3,
  parameter int CPR_CYC    = 5,
  parameter int PRE_CYC    = 7,
  parameter int RASMIN_CYC = 12,
  parameter int CSR_CYC    = 2,
  parameter int HIT_LIM    = 90,
  parameter int CNT_W      = 5,
  parameter int RAS_W      = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       rowHit,
  input  logic       refReq,
  output logic       reqReady,
  output edoStrobe_t stb
);

  localparam logic [RAS_W-1:0] HIT_L = RAS_W'(HIT_LIM);
  localparam logic [RAS_W-1:0] MIN_L = RAS_W'(RASMIN_CYC);

  edoState_t state, nxt;
  logic [CNT_W-1:0] cnt, loadCnt;
  logic [RAS_W-1:0] rasCnt;
  logic opWrite;
  logic keepRow;

  always_comb begin
    stb      = '0;
    nxt      = state;
    reqReady = 1'b0;
    keepRow  = !refReq && (rasCnt < HIT_L);
    unique case (state)
      ST_IDLE: begin
        if (refReq) nxt = ST_REFCAS;
        else begin
          reqReady = 1'b1;
          if (reqValid) begin
            stb.capture = 1'b1;
            nxt = ST_ROW;
          end
        end
      end
      ST_ROW: begin
        stb.rasOn = 1'b1;
        if (cnt == '0) nxt = ST_COLSET;
      end
      ST_COLSET, ST_CASLO: begin
        stb.rasOn   = 1'b1;
        stb.colSel  = 1'b1;
        stb.weOn    = opWrite;
        stb.dqDrive = opWrite;
        stb.oeOn    = !opWrite;
        stb.casOn   = (state == ST_CASLO);
        if (state == ST_COLSET) nxt = ST_CASLO;
        else if (cnt == '0) nxt = ST_CASHI;
      end
      ST_CASHI: begin
        stb.rasOn  = 1'b1;
        stb.colSel = 1'b1;
        stb.oeOn   = !opWrite;
        if (cnt == '0) begin
          stb.sample = !opWrite;
          nxt = ST_OPEN;
        end
      end
      ST_OPEN: begin
        stb.rasOn = 1'b1;
        if (keepRow && reqValid && rowHit) begin
          reqReady    = 1'b1;
          stb.capture = 1'b1;
          nxt = ST_COLSET;
        end else if ((!keepRow || reqValid) && rasCnt >= MIN_L) begin
          nxt = ST_PRE;
        end
      end
      ST_PRE: begin
        if (cnt == '0) nxt = ST_IDLE;
      end
      ST_REFCAS: begin
        stb.casOn = 1'b1;
        if (cnt == '0) nxt = ST_REFRAS;
      end
      ST_REFRAS: begin
        stb.casOn = 1'b1;
        stb.rasOn = 1'b1;
        if (cnt == '0) begin
          stb.ack = 1'b1;
          nxt = ST_PRE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (nxt)
      ST_ROW:    loadCnt = CNT_W'(RCD_CYC - 1);
      ST_CASLO:  loadCnt = CNT_W'(CAS_CYC - 1);
      ST_CASHI:  loadCnt = opWrite ? CNT_W'(CPW_CYC - 1) : CNT_W'(CPR_CYC - 1);
      ST_PRE:    loadCnt = CNT_W'(PRE_CYC - 1);
      ST_REFCAS: loadCnt = CNT_W'(CSR_CYC - 1);
      ST_REFRAS: loadCnt = CNT_W'(RASMIN_CYC - 1);
      default:   loadCnt = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rasCnt  <= '0;
      opWrite <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt != state) cnt <= loadCnt;
      else if (cnt != '0) cnt <= cnt - 1'b1;
      rasCnt <= stb.rasOn ? rasCnt + 1'b1 : '0;
      if (stb.capture) opWrite <= reqWrite;
    end
  end

endmodule

// File: rtl/edo_datapath.sv
module edo_datapath
  import edo_pkg::*;
#(
  parameter int ROW_W  = 11,
  parameter int COL_W  = 11,
  parameter int DQ_W   = 4,
  parameter int ADDR_W = ROW_W + COL_W,
  parameter int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  edoStrobe_t        stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DQ_W-1:0]   reqWdata,
  input  logic [DQ_W-1:0]   dramDqIn,
  output logic              rowHit,
  output logic [PIN_W-1:0]  dramA,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              dramWeN,
  output logic              dramOeN,
  output logic [DQ_W-1:0]   dramDq,
  output logic              dramDqOe,
  output logic              rspValid,
  output logic [DQ_W-1:0]   rspData,
  output logic              refAck
);

  logic [ROW_W-1:0] rowReg;
  logic [COL_W-1:0] colReg;
  logic [DQ_W-1:0]  dataReg;

  assign rowHit = (reqAddr[ADDR_W-1:COL_W] == rowReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rowReg   <= '0;
      colReg   <= '0;
      dataReg  <= '0;
      dramA    <= '0;
      dramRasN <= 1'b1;
      dramCasN <= 1'b1;
      dramWeN  <= 1'b1;
      dramOeN  <= 1'b1;
      dramDq   <= '0;
      dramDqOe <= 1'b0;
      rspValid <= 1'b0;
      rspData  <= '0;
      refAck   <= 1'b0;
    end else begin
      if (stb.capture) begin
        rowReg  <= reqAddr[ADDR_W-1:COL_W];
        colReg  <= reqAddr[COL_W-1:0];
        dataReg <= reqWdata;
      end
      dramA    <= stb.colSel ? PIN_W'(colReg) : PIN_W'(rowReg);
      dramRasN <= !stb.rasOn;
      dramCasN <= !stb.casOn;
      dramWeN  <= !stb.weOn;
      dramOeN  <= !stb.oeOn;
      dramDq   <= dataReg;
      dramDqOe <= stb.dqDrive;
      rspValid <= stb.sample;
      if (stb.sample) rspData <= dramDqIn;
      refAck   <= stb.ack;
    end
  end

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int CLK_NS      = 4,
  parameter int T_RCD_NS    = 10,
  parameter int T_CAS_NS    = 7,
  parameter int T_CP_NS     = 7,
  parameter int T_PC_NS     = 18,
  parameter int T_RP_NS     = 27,
  parameter int T_RAS_NS    = 45,
  parameter int T_RC_NS     = 76,
  parameter int T_CSR_NS    = 5,
  parameter int T_ACC_NS    = 21,
  parameter int T_RASMAX_NS = 200000,
  parameter int ROW_W       = 11,
  parameter int COL_W       = 11,
  parameter int DQ_W        = 4,
  parameter int ADDR_W      = ROW_W + COL_W,
  parameter int PIN_W       = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DQ_W-1:0]   reqWdata,
  output logic              rspValid,
  output logic [DQ_W-1:0]   rspData,
  input  logic              refReq,
  output logic              refAck,
  output logic [PIN_W-1:0]  dramA,
  output logic              dramRasN,
  output logic              dramCasN,
  output logic              dramWeN,
  output logic              dramOeN,
  output logic [DQ_W-1:0]   dramDq,
  output logic              dramDqOe,
  input  logic [DQ_W-1:0]   dramDqIn
);

  localparam int RCD_CYC    = cdiv(T_RCD_NS, CLK_NS);
  localparam int CAS_CYC    = cdiv(T_CAS_NS, CLK_NS);
  localparam int CPW_CYC    = imax(cdiv(T_CP_NS, CLK_NS), cdiv(T_PC_NS, CLK_NS) - CAS_CYC);
  localparam int CPR_CYC    = imax(CPW_CYC, cdiv(T_ACC_NS, CLK_NS) - CAS_CYC + 1);
  localparam int RASMIN_CYC = cdiv(T_RAS_NS, CLK_NS);
  localparam int PRE_CYC    = imax(cdiv(T_RP_NS, CLK_NS), cdiv(T_RC_NS, CLK_NS) - RASMIN_CYC);
  localparam int CSR_CYC    = imax(cdiv(T_CSR_NS, CLK_NS), 1);
  localparam int RASMAX_CYC = T_RASMAX_NS / CLK_NS;
  localparam int HIT_LIM    = RASMAX_CYC - (CAS_CYC + CPR_CYC + 3);
  localparam int CNT_W      = $clog2(imax(imax(PRE_CYC, RASMIN_CYC), imax(CPR_CYC, RCD_CYC)) + 1) + 1;
  localparam int RAS_W      = $clog2(RASMAX_CYC + 1) + 1;

  edoStrobe_t stb;
  logic rowHit;

  edo_ctrl #(
    .RCD_CYC(RCD_CYC), .CAS_CYC(CAS_CYC), .CPW_CYC(CPW_CYC), .CPR_CYC(CPR_CYC),
    .PRE_CYC(PRE_CYC), .RASMIN_CYC(RASMIN_CYC), .CSR_CYC(CSR_CYC),
    .HIT_LIM(HIT_LIM), .CNT_W(CNT_W), .RAS_W(RAS_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .rowHit(rowHit), .refReq(refReq), .reqReady(reqReady), .stb(stb)
  );

  edo_datapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DQ_W(DQ_W), .ADDR_W(ADDR_W), .PIN_W(PIN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .dramDqIn(dramDqIn), .rowHit(rowHit), .dramA(dramA), .dramRasN(dramRasN),
    .dramCasN(dramCasN), .dramWeN(dramWeN), .dramOeN(dramOeN), .dramDq(dramDq),
    .dramDqOe(dramDqOe), .rspValid(rspValid), .rspData(rspData), .refAck(refAck)
  );

endmodule

// File: rtl/edo_page_ctrl_chk.sv
module edo_page_ctrl_chk #(
  parameter int RASMAX_CYC = 100,
  parameter int PRE_CYC    = 7
) (
  input logic clk,
  input logic rstN,
  input logic dramRasN,
  input logic dramCasN,
  input logic dramWeN,
  input logic dramOeN,
  input logic dramDqOe,
  input logic rspValid,
  input logic refReq,
  input logic reqReady,
  input logic refAck
);

  int unsigned lowCnt;
  int unsigned highCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lowCnt  <= 0;
      highCnt <= PRE_CYC;
    end else begin
      lowCnt <= dramRasN ? 0 : lowCnt + 1;
      if (!dramRasN) highCnt <= 0;
      else if (highCnt < PRE_CYC) highCnt <= highCnt + 1;
    end
  end

  p_oe_high_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    !dramWeN |-> dramOeN);

  p_dq_only_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    dramDqOe |-> !dramWeN);

  p_ras_limit_r6: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= RASMAX_CYC);

  p_precharge_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |-> highCnt >= PRE_CYC);

  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    refAck |=> !refAck);

  p_ref_block_r7: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> !reqReady);

  p_sample_cas_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> dramCasN && $past(dramCasN));

  p_sample_oe_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !$past(dramOeN) && $past(dramWeN));

endmodule

bind edo_page_ctrl edo_page_ctrl_chk #(
  .RASMAX_CYC(RASMAX_CYC), .PRE_CYC(PRE_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .dramRasN(dramRasN), .dramCasN(dramCasN),
  .dramWeN(dramWeN), .dramOeN(dramOeN), .dramDqOe(dramDqOe),
  .rspValid(rspValid), .refReq(refReq), .reqReady(reqReady), .refAck(refAck)
);

// File: tb/edo_page_ctrl_tb.sv
`timescale 1ns/1ps
module edo_page_ctrl_tb;

  localparam int RASMAX_EXP = 100;  // 400 ns / 4 ns
  localparam int PRE_EXP    = 7;
  localparam int RCD_EXP    = 3;
  localparam int CAS_EXP    = 2;
  localparam int RASMIN_EXP = 12;

  // {write, row, col, data}; for reads data is the expected word
  localparam logic [26:0] VEC [11] = '{
    {1'b1, 11'd5,     11'd3,     4'hA},
    {1'b1, 11'd5,     11'd9,     4'h5},
    {1'b0, 11'd5,     11'd3,     4'hA},
    {1'b0, 11'd5,     11'd9,     4'h5},
    {1'b1, 11'h7FF,   11'h7FF,   4'hC},
    {1'b0, 11'd5,     11'd3,     4'hA},
    {1'b1, 11'd5,     11'd0,     4'h3},
    {1'b0, 11'h7FF,   11'h7FF,   4'hC},
    {1'b0, 11'd5,     11'd0,     4'h3},
    {1'b1, 11'd0,     11'd1,     4'h9},
    {1'b0, 11'd0,     11'd1,     4'h9}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0, refReq = 1'b0;
  logic [21:0] reqAddr = '0;
  logic [3:0] reqWdata = '0;
  logic reqReady, rspValid, refAck, dramRasN, dramCasN, dramWeN, dramOeN, dramDqOe;
  logic [3:0] rspData, dramDq, dramDqIn;
  logic [10:0] dramA;

  always #2 clk = ~clk;

  edo_page_ctrl #(.T_RASMAX_NS(400)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .refReq(refReq), .refAck(refAck),
    .dramA(dramA), .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
    .dramOeN(dramOeN), .dramDq(dramDq), .dramDqOe(dramDqOe), .dramDqIn(dramDqIn)
  );

  // behavioural memory
  logic [3:0] mem [int unsigned];
  logic [10:0] rowLat = '0;
  logic [3:0] rdVal = '0;
  logic rdValid = 1'b0, mRasPrev = 1'b1, mCasPrev = 1'b1;
  assign dramDqIn = rdValid ? rdVal : 4'h0;

  always @(dramRasN or dramCasN or dramOeN or dramWeN) begin
    if (!dramRasN && mRasPrev && dramCasN) rowLat = dramA;
    if (!dramCasN && mCasPrev && !dramRasN) begin
      if (!dramWeN) mem[{rowLat, dramA}] = dramDq;
      else begin
        rdVal = mem.exists({rowLat, dramA}) ? mem[{rowLat, dramA}] : 4'h0;
        rdValid = 1'b1;
      end
    end
    if (dramRasN || dramOeN || !dramWeN) rdValid = 1'b0;
    mRasPrev = dramRasN;
    mCasPrev = dramCasN;
  end

  // pin monitor, sampled mid-cycle
  int rasFalls = 0, casFalls = 0, cbrCnt = 0, ackSeen = 0;
  int lowRun = 0, highRun = 0, casRun = 0, ackRun = 0;
  int maxRasLow = 0, minRasLow = 9999, minRasHigh = 9999, minCasLow = 9999;
  int minRasToCas = 9999, maxAck = 0;
  int earlyViol = 0, dqViol = 0, oeViol = 0, rspCasViol = 0;
  logic [10:0] rowSeen = '0, colSeen = '0;
  logic pRas = 1'b1, pCas = 1'b1, pWe = 1'b1, seenFall = 1'b0, firstCas = 1'b0;

  always @(negedge clk) if (rstN) begin
    if (!pRas && dramRasN) begin
      if (lowRun < minRasLow) minRasLow = lowRun;
      highRun = 0;
    end
    if (pRas && !dramRasN) begin
      rasFalls++;
      if (dramCasN) begin rowSeen = dramA; firstCas = 1'b1; end
      else cbrCnt++;
      if (seenFall && highRun < minRasHigh) minRasHigh = highRun;
      seenFall = 1'b1;
      lowRun = 0;
    end
    if (!dramRasN) begin
      lowRun++;
      if (lowRun > maxRasLow) maxRasLow = lowRun;
    end else highRun++;
    if (pCas && !dramCasN && !dramRasN) begin
      casFalls++;
      colSeen = dramA;
      if (firstCas && (lowRun - 1) < minRasToCas) minRasToCas = lowRun - 1;
      firstCas = 1'b0;
      if (!dramWeN && pWe) earlyViol++;
    end
    if (!pCas && dramCasN && casRun < minCasLow) minCasLow = casRun;
    casRun = dramCasN ? 0 : casRun + 1;
    if (dramDqOe && !(!dramWeN && dramOeN)) dqViol++;
    if (!dramWeN && !dramOeN) oeViol++;
    if (rspValid && !dramCasN) rspCasViol++;
    if (refAck) begin
      if (ackRun == 0) ackSeen++;
      ackRun++;
      if (ackRun > maxAck) maxAck = ackRun;
    end else ackRun = 0;
    pRas = dramRasN; pCas = dramCasN; pWe = dramWeN;
  end

  int nChecks = 0, nErr = 0;

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic wr, input logic [21:0] a, input logic [3:0] d);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    #0.5;
    while (!reqReady) begin @(negedge clk); #0.5; end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitRsp(output logic [3:0] d, output logic got);
    got = 1'b0; d = '0;
    if (rspValid) begin got = 1'b1; d = rspData; end
    for (int t = 0; t < 200 && !got; t++) begin
      @(negedge clk);
      if (rspValid) begin got = 1'b1; d = rspData; end
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    logic [3:0] d;
    logic got;
    int f1, c1, cb1, ac1;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(dramRasN && dramCasN && dramWeN && dramOeN && !dramDqOe && !rspValid && !refAck,
          "R9 reset pins", {dramRasN, dramCasN, dramWeN, dramOeN, dramDqOe}, 5'b11110);
    @(negedge clk); rstN = 1'b1;
    #0.5;
    check(reqReady === 1'b1, "R9 ready after reset", reqReady, 1);

    for (int i = 0; i < 11; i++) begin
      send(VEC[i][26], VEC[i][25:4], VEC[i][3:0]);
      if (!VEC[i][26]) begin
        waitRsp(d, got);
        check(got && d == VEC[i][3:0], "R2 read data", d, VEC[i][3:0]);
        check(rowSeen == VEC[i][25:15] && colSeen == VEC[i][14:4], "R1 address split",
              {rowSeen, colSeen}, VEC[i][25:4]);
      end
    end

    // R4: page hit keeps RAS low
    send(1'b0, {11'd5, 11'd0}, 4'h0);
    waitRsp(d, got);
    f1 = rasFalls; c1 = casFalls;
    send(1'b0, {11'd5, 11'd3}, 4'h0);
    waitRsp(d, got);
    check(got && d == 4'hA, "R4 hit data", d, 4'hA);
    check(rasFalls == f1, "R4 no new row strobe", rasFalls, f1);
    check(casFalls == c1 + 1, "R4 one column strobe", casFalls, c1 + 1);
    check(rspCasViol == 0, "R4 sample with CAS high", rspCasViol, 0);

    // R6: idle open page must close before the limit
    repeat (150) @(negedge clk);
    check(dramRasN == 1'b1, "R6 row closed on limit", dramRasN, 1);
    check(maxRasLow <= RASMAX_EXP && maxRasLow >= RASMAX_EXP - 12, "R6 RAS low max",
          maxRasLow, RASMAX_EXP);

    // R7: refresh and request in the same idle cycle
    cb1 = cbrCnt; ac1 = ackSeen;
    @(negedge clk);
    refReq = 1'b1; reqValid = 1'b1; reqWrite = 1'b0; reqAddr = {11'd5, 11'd9};
    #0.5;
    check(reqReady == 1'b0, "R7 request held off", reqReady, 0);
    for (int t = 0; t < 100 && ackSeen == ac1; t++) @(negedge clk);
    refReq = 1'b0;
    check(cbrCnt == cb1 + 1, "R7 CAS before RAS refresh", cbrCnt, cb1 + 1);
    check(ackSeen == ac1 + 1, "R7 ack seen", ackSeen, ac1 + 1);
    #0.5;
    while (!reqReady) begin @(negedge clk); #0.5; end
    @(negedge clk); reqValid = 1'b0;
    waitRsp(d, got);
    check(got && d == 4'h5, "R7 request after refresh", d, 4'h5);

    // R7: refresh while a row is open
    send(1'b0, {11'd0, 11'd1}, 4'h0);
    waitRsp(d, got);
    cb1 = cbrCnt;
    @(negedge clk); refReq = 1'b1;
    for (int t = 0; t < 100 && cbrCnt == cb1; t++) @(negedge clk);
    for (int t = 0; t < 40 && !refAck; t++) @(negedge clk);
    @(negedge clk); refReq = 1'b0;
    check(cbrCnt == cb1 + 1, "R7 refresh from open row", cbrCnt, cb1 + 1);
    check(maxAck == 1, "R7 ack one cycle", maxAck, 1);

    // R10: miss right after a single access
    send(1'b0, {11'd9, 11'd9}, 4'h0);
    send(1'b0, {11'd10, 11'd9}, 4'h0);
    repeat (60) @(negedge clk);

    check(earlyViol == 0, "R3 early write", earlyViol, 0);
    check(dqViol == 0, "R3 pads only on write", dqViol, 0);
    check(oeViol == 0, "R3 OE high in write", oeViol, 0);
    check(minRasHigh >= PRE_EXP, "R5 precharge", minRasHigh, PRE_EXP);
    check(minRasToCas >= RCD_EXP, "R8 RAS to CAS", minRasToCas, RCD_EXP);
    check(minCasLow == CAS_EXP, "R8 CAS width", minCasLow, CAS_EXP);
    check(minRasLow >= RASMIN_EXP, "R10 RAS low min", minRasLow, RASMIN_EXP);
    finishRun();
  end

endmodule